// File: doc/BRIEF.md
# Iterative Shift-and-Add Multiplier with Selectable Product Half

This block multiplies two XLEN-bit operands over XLEN clock cycles with a single adder, one partial-product step per cycle. The add and the shift happen in the same cycle. An operation code picks how the operands are interpreted and which half of the double-width product is returned. The low half is the same for every signedness. The upper half is available with both operands signed, both unsigned, or the first signed and the second unsigned.

A request is made by raising the start input with the operation code and both operands. While the block is busy, further requests are ignored. When the product is finished, the done output is high for one cycle. The XLEN-bit result is valid from that cycle and stays unchanged until the next completion. Signed operands are reduced to their magnitudes before the loop. The finished product is negated when exactly one signed operand was negative.

Top module: `seq_mul`

## Requirements
- R1: During and right after synchronous active-low reset, `busy_o` and `done_o` are low and `result_o` is zero.
- R2: A start accepted while idle raises `busy_o` in the next cycle. `done_o` is high for exactly one cycle, XLEN cycles after the accepting edge, and `busy_o` falls at that same edge.
- R3: `start_i` raised while `busy_o` is high is ignored. The running operation finishes on schedule with its own operands and operation code.
- R4: Operation code 2'b00 returns bits [XLEN-1:0] of the product. The value is identical whether the operands are read as signed or unsigned.
- R5: Operation code 2'b01 returns bits [2*XLEN-1:XLEN] of the product with both operands read as two's-complement signed.
- R6: Operation code 2'b10 returns bits [2*XLEN-1:XLEN] of the product with `opa_i` read as signed and `opb_i` read as unsigned.
- R7: Operation code 2'b11 returns bits [2*XLEN-1:XLEN] of the product with both operands read as unsigned.
- R8: `result_o` changes only on the cycle `done_o` is high and otherwise holds its last value.
- R9: Most-negative signed operands are handled exactly. For example, the signed upper half of the most negative value squared is 2^(XLEN-2).
- R10: A start presented in the cycle `done_o` is high is accepted, so operations can run back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a multiplication (taken only when idle) |
| op_i | input | 2 | Operation code: 00 low, 01 signed high, 10 signed-by-unsigned high, 11 unsigned high |
| opa_i | input | XLEN | First operand (multiplicand) |
| opb_i | input | XLEN | Second operand (multiplier) |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | XLEN | Selected product half, held until the next completion |

## Verification
Once a start is accepted, `busy_o` is due one edge later. `done_o` and the new `result_o` are due at the XLEN-th rising edge after the accepting one. The reference model in the bench advances one step per rising edge and keeps its own countdown. It is compared with the design at the following falling edge on every cycle. The expected product halves come from wide multiplication of the sign- or zero-extended operands. They are loaded into the model when the start is accepted and shown at the countdown's end. As a result, an early, late, stretched or missing pulse shows up in the exact cycle it happens.

// File: rtl/seq_mul_pkg.sv
// Shared operation codes for the sequential multiplier.
// Assumes a 2-bit operation field; the codes are part of the block's interface.
package seq_mul_pkg;

    typedef enum logic [1:0] {
        MUL_LO    = 2'b00,
        MUL_HI_SS = 2'b01,
        MUL_HI_SU = 2'b10,
        MUL_HI_UU = 2'b11
    } mul_op_e;

    // True when the first operand is read as signed for this operation.
    function automatic logic a_is_signed(input mul_op_e op);
        return (op == MUL_HI_SS) || (op == MUL_HI_SU);
    endfunction

    // True when the second operand is read as signed for this operation.
    function automatic logic b_is_signed(input mul_op_e op);
        return (op == MUL_HI_SS);
    endfunction

endpackage

// File: rtl/seq_mul_sign.sv
// Operand conditioner: turns each operand into a magnitude and records
// whether the final product must be negated.
// Assumes two's-complement inputs; the most negative value maps to
// 2^(XLEN-1), which still fits in XLEN unsigned bits.
module seq_mul_sign
    import seq_mul_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  mul_op_e           op,
    input  logic [XLEN-1:0]   opa,
    input  logic [XLEN-1:0]   opb,
    output logic [XLEN-1:0]   mag_a,
    output logic [XLEN-1:0]   mag_b,
    output logic              negate
);

    logic a_neg;
    logic b_neg;

    // Decide operand signs and form magnitudes.
    always_comb begin
        a_neg  = a_is_signed(op) & opa[XLEN-1];
        b_neg  = b_is_signed(op) & opb[XLEN-1];
        mag_a  = a_neg ? (~opa + XLEN'(1)) : opa;
        mag_b  = b_neg ? (~opb + XLEN'(1)) : opb;
        negate = a_neg ^ b_neg;
    end

endmodule

// File: rtl/seq_mul_step.sv
// One partial-product step: conditional add of the multiplicand into the
// upper half and a right shift of the whole product register, combined.
// Assumes the multiplier occupies the low half of the product register.
module seq_mul_step #(
    parameter int XLEN = 64
) (
    input  logic [2*XLEN-1:0] prod_cur,
    input  logic [XLEN-1:0]   mcand,
    output logic [2*XLEN-1:0] prod_nxt
);

    logic [XLEN:0] upper_sum;

    // Add when the current multiplier bit is one, then shift right by one.
    always_comb begin
        upper_sum = {1'b0, prod_cur[2*XLEN-1:XLEN]}
                  + (prod_cur[0] ? {1'b0, mcand} : {(XLEN+1){1'b0}});
        prod_nxt  = {upper_sum, prod_cur[XLEN-1:1]};
    end

endmodule

// File: rtl/seq_mul_ctrl.sv
// Sequencer: accepts a start when idle, counts XLEN steps, raises a
// one-cycle done pulse at the last step. Starts while busy are dropped.
module seq_mul_ctrl #(
    parameter int XLEN = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic accept,
    output logic step_en,
    output logic last,
    output logic busy,
    output logic done
);

    localparam int CW = $clog2(XLEN + 1);

    logic [CW-1:0] remain_q;
    logic          busy_q;
    logic          done_q;

    // Decode the handshake from the current state.
    always_comb begin
        accept  = start && !busy_q;
        step_en = busy_q;
        last    = busy_q && (remain_q == CW'(1));
    end

    // Track remaining steps and the busy/done flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                remain_q <= CW'(XLEN);
                busy_q   <= 1'b1;
            end else if (busy_q) begin
                remain_q <= remain_q - CW'(1);
                if (last) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;

endmodule

// File: rtl/seq_mul_out.sv
// Result stage: restores the product sign and picks the requested half.
// Assumes the input is the unsigned product of the two magnitudes.
module seq_mul_out
    import seq_mul_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [2*XLEN-1:0] prod_mag,
    input  logic              negate,
    input  mul_op_e           op,
    output logic [XLEN-1:0]   word
);

    logic [2*XLEN-1:0] full;

    // Apply the sign and select the low or high half.
    always_comb begin
        full = negate ? (~prod_mag + (2*XLEN)'(1)) : prod_mag;
        word = (op == MUL_LO) ? full[XLEN-1:0] : full[2*XLEN-1:XLEN];
    end

endmodule

// File: rtl/seq_mul.sv
// Iterative XLEN x XLEN multiplier returning one XLEN-bit product half.
// Takes XLEN cycles per operation; one adder shared over all steps.
// Assumes operands and op are sampled only in the accepting cycle.
module seq_mul
    import seq_mul_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [1:0]      op_i,
    input  logic [XLEN-1:0] opa_i,
    input  logic [XLEN-1:0] opb_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [XLEN-1:0] result_o
);

    localparam int PW = 2 * XLEN;

    mul_op_e           op_in;
    logic [XLEN-1:0]   mag_a;
    logic [XLEN-1:0]   mag_b;
    logic              neg_in;
    logic              accept;
    logic              step_en;
    logic              last;
    logic [PW-1:0]     prod_q;
    logic [PW-1:0]     prod_d;
    logic [XLEN-1:0]   mcand_q;
    logic              neg_q;
    mul_op_e           op_q;
    logic [XLEN-1:0]   word;
    logic [XLEN-1:0]   result_q;

    assign op_in = mul_op_e'(op_i);

    seq_mul_sign #(.XLEN(XLEN)) u_sign (
        .op     (op_in),
        .opa    (opa_i),
        .opb    (opb_i),
        .mag_a  (mag_a),
        .mag_b  (mag_b),
        .negate (neg_in)
    );

    seq_mul_ctrl #(.XLEN(XLEN)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_i),
        .accept  (accept),
        .step_en (step_en),
        .last    (last),
        .busy    (busy_o),
        .done    (done_o)
    );

    seq_mul_step #(.XLEN(XLEN)) u_step (
        .prod_cur (prod_q),
        .mcand    (mcand_q),
        .prod_nxt (prod_d)
    );

    seq_mul_out #(.XLEN(XLEN)) u_out (
        .prod_mag (prod_d),
        .negate   (neg_q),
        .op       (op_q),
        .word     (word)
    );

    // Load operands on accept, then advance one step per busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q  <= '0;
            mcand_q <= '0;
            neg_q   <= 1'b0;
            op_q    <= MUL_LO;
        end else if (accept) begin
            prod_q  <= {{XLEN{1'b0}}, mag_b};
            mcand_q <= mag_a;
            neg_q   <= neg_in;
            op_q    <= op_in;
        end else if (step_en) begin
            prod_q  <= prod_d;
        end
    end

    // Capture the selected half on the final step and hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (last) begin
            result_q <= word;
        end
    end

    assign result_o = result_q;

endmodule

// File: rtl/seq_mul_chk.sv
// Protocol checker for seq_mul, attached with bind below.
// Counts cycles since the accepted start to check the done latency.
module seq_mul_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic            busy_o,
    input logic            done_o,
    input logic [XLEN-1:0] result_o
);

    int unsigned elapsed;

    // Cycles since the last accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)                   elapsed <= 0;
        else if (start_i && !busy_o)  elapsed <= 0;
        else if (busy_o)              elapsed <= elapsed + 1;
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !done_o && result_o == '0));

    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (elapsed == XLEN));

    assert_done_not_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && busy_o));

    assert_busy_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && elapsed < XLEN - 1) |=> busy_o);

    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |=> (done_o || $stable(result_o)));

endmodule

bind seq_mul seq_mul_chk #(.XLEN(XLEN)) u_seq_mul_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o)
);

// File: tb/test_seq_mul.sv
module test_seq_mul;

    localparam int XLEN   = 64;
    localparam int CLK_NS = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [1:0]      op_i = 2'b00;
    logic [XLEN-1:0] opa_i = '0;
    logic [XLEN-1:0] opb_i = '0;
    logic            busy_o;
    logic            done_o;
    logic [XLEN-1:0] result_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // reference model state
    bit              m_busy = 0;
    bit              m_done = 0;
    int              m_cnt = 0;
    logic [XLEN-1:0] m_res = '0;
    logic [XLEN-1:0] m_pend = '0;
    string           m_tag = "R1";
    string           m_pend_tag = "R1";

    seq_mul #(.XLEN(XLEN)) i_seq_mul (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o), .done_o(done_o),
        .result_o(result_o)
    );

    always #(CLK_NS/2) clk = ~clk;

    function automatic logic [XLEN-1:0] expect_word(input logic [1:0] op,
                                                    input logic [XLEN-1:0] a,
                                                    input logic [XLEN-1:0] b);
        logic [2*XLEN-1:0] ea, eb, p;
        ea = {{XLEN{(op == 2'b01 || op == 2'b10) & a[XLEN-1]}}, a};
        eb = {{XLEN{(op == 2'b01) & b[XLEN-1]}}, b};
        p  = ea * eb;
        return (op == 2'b00) ? p[XLEN-1:0] : p[2*XLEN-1:XLEN];
    endfunction

    task automatic check(input string tag, input logic [XLEN-1:0] act,
                         input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // One clock: drive inputs, advance model at the edge, compare at negedge.
    task automatic cycle(input bit st, input logic [1:0] op,
                         input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                         input string tag);
        start_i = st; op_i = op; opa_i = a; opb_i = b;
        @(posedge clk);
        m_done = 0;
        if (!m_busy && st) begin
            m_busy = 1; m_cnt = XLEN;
            m_pend = expect_word(op, a, b); m_pend_tag = tag;
        end else if (m_busy) begin
            m_cnt--;
            if (m_cnt == 0) begin
                m_busy = 0; m_done = 1; m_res = m_pend; m_tag = m_pend_tag;
            end
        end
        @(negedge clk);
        check("R2 busy", XLEN'(busy_o), XLEN'(m_busy));
        check("R2 done", XLEN'(done_o), XLEN'(m_done));
        if (m_done) check(m_tag, result_o, m_res);
        else        check("R8 hold", result_o, m_res);
    endtask

    task automatic run_op(input logic [1:0] op, input logic [XLEN-1:0] a,
                          input logic [XLEN-1:0] b, input string tag);
        cycle(1, op, a, b, tag);
        for (int i = 0; i < XLEN; i++) cycle(0, 2'b00, '0, '0, tag);
    endtask

    initial begin
        #(CLK_NS * 200000);
        failures++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    localparam logic [XLEN-1:0] MINV = {1'b1, {(XLEN-1){1'b0}}};
    localparam logic [XLEN-1:0] ONES = '1;

    initial begin
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 busy", XLEN'(busy_o), '0);
        check("R1 done", XLEN'(done_o), '0);
        check("R1 result", result_o, '0);
        rst_n = 1;
        cycle(0, 2'b00, '0, '0, "R1");

        // R4: low product, several patterns including negative operands
        run_op(2'b00, 64'd7, 64'd6, "R4 low");
        run_op(2'b00, -64'sd7, 64'd6, "R4 low neg");
        run_op(2'b00, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, "R4 low mix");
        // R5: signed high
        run_op(2'b01, -64'sd3, 64'd5, "R5 sh neg*pos");
        run_op(2'b01, -64'sd3, -64'sd5, "R5 sh neg*neg");
        run_op(2'b01, 64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, "R5 sh max");
        // R9: most negative corners
        run_op(2'b01, MINV, MINV, "R9 min*min");
        run_op(2'b01, MINV, ONES, "R9 min*-1");
        run_op(2'b10, MINV, ONES, "R9 su min*umax");
        // R6: signed by unsigned high
        run_op(2'b10, -64'sd2, ONES, "R6 su neg*big");
        run_op(2'b10, 64'd9, ONES, "R6 su pos*big");
        // R7: unsigned high
        run_op(2'b11, ONES, ONES, "R7 uh ones");
        run_op(2'b11, 64'hDEAD_BEEF_0000_0001, 64'd0, "R7 uh zero");
        run_op(2'b11, 64'h8000_0000_0000_0001, 64'h3, "R7 uh small");

        // R3: start while busy is ignored
        cycle(1, 2'b11, ONES, ONES, "R3 first");
        for (int i = 0; i < XLEN; i++) begin
            if (i == 5 || i == XLEN - 2)
                cycle(1, 2'b00, 64'd2, 64'd3, "R3 ignored");
            else
                cycle(0, 2'b00, '0, '0, "R3");
        end
        // R8: result held over idle cycles
        repeat (4) cycle(0, 2'b01, 64'd4, 64'd4, "R8");

        // R10: back-to-back starts in the done cycle (run_op ends on done)
        run_op(2'b01, -64'sd1, -64'sd1, "R10 b2b a");
        run_op(2'b00, ONES, ONES, "R10 b2b b");
        run_op(2'b10, 64'd1, 64'd1, "R10 b2b c");
        cycle(0, 2'b00, '0, '0, "R10 idle");

        finish_run();
    end

endmodule